// File: doc/BRIEF.md
# BT.709 Colour Space Converter

This block converts 10-bit 4:4:4 video samples between R'G'B' and Y'CbCr with the BT.709 luma weights (red 0.2126, blue 0.0722, green the remainder) at narrow-range levels. It can also pass samples through unchanged. Each sample carries its own two-bit mode. A format detector upstream can therefore flip the direction between frames, or even between adjacent samples, without draining the pipeline. Every sample that arrives with `in_valid` high leaves three clock cycles later with `out_valid` high. The component order on the ports is R, G, B for R'G'B' and Y, Cb, Cr for Y'CbCr.

The datapath is signed fixed point. Each rounding step adds half an LSB and then truncates, and every final result is clamped into 0..1023. Going forward, luma is rounded to an integer first, and the two colour-difference values are then formed from that rounded luma. Going back, all three outputs are produced from one rounded matrix product. A single pass is therefore within one code of the exact value. A full round trip is within two codes, and exact recovery is not a goal.

Top module: `csc_bt709`

## Requirements
- R1: `in_mode` is captured with each sample. 0 or 3 passes the three components through unchanged, 1 converts R'G'B' to Y'CbCr, and 2 converts Y'CbCr to R'G'B'.
- R2: In mode 1, output component 0 is Y = round(0.2126·R + 0.7152·G + 0.0722·B). For example, (255,0,0) gives Y = 54.
- R3: In mode 1, Cb = 512 + round((B−Y)·(224/219)/1.8556) and Cr = 512 + round((R−Y)·(224/219)/1.5748), using the rounded Y. Examples: (255,0,0)→(54,482,643), (940,64,64)→(250,409,960), (0,255,0)→(182,412,394), (64,64,64)→(64,512,512).
- R4: In mode 2, with b = Cb−512 and r = Cr−512, R = Y + 1.539648·r, G = Y − 0.183143·b − 0.457676·r and B = Y + 1.814181·b, each rounded. Examples: (54,482,643)→(256,0,0), (250,409,960)→(940,64,63), (182,412,394)→(0,254,1).
- R5: Rounding is to nearest. A mode 1 conversion followed by a mode 2 conversion returns each component within ±2 codes of the original.
- R6: Every converted output is clamped to 0..1023. Examples: mode 1 (0,0,1023)→(74,1023,464), mode 2 (0,512,1023)→(787,0,0), mode 2 (0,0,0)→(0,328,0).
- R7: `out_valid` equals `in_valid` from exactly three clock edges earlier, and the data appears in that same cycle.
- R8: A change of mode applies only to samples presented with the new mode. Back-to-back samples with different modes are each converted under their own mode.
- R9: While `rst_n` is low, `out_valid` and all output components are 0 after the next clock edge.
- R10: Neutral values stay neutral. In mode 1, equal R, G and B give Y equal to that value and Cb = Cr = 512. In mode 2, Cb = Cr = 512 gives R = G = B = Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_mode | input | 2 | Per-sample mode: 0/3 pass, 1 to Y'CbCr, 2 to R'G'B' |
| in_c0 | input | 10 | Component 0 (R or Y) |
| in_c1 | input | 10 | Component 1 (G or Cb) |
| in_c2 | input | 10 | Component 2 (B or Cr) |
| out_valid | output | 1 | Output sample strobe, three cycles after input |
| out_c0 | output | 10 | Result component 0 (Y or R) |
| out_c1 | output | 10 | Result component 1 (Cb or G) |
| out_c2 | output | 10 | Result component 2 (Cr or B) |

## Verification
A mode change and the conversion of samples already in flight can fall in the same cycle. The bench provokes this with three samples on consecutive cycles in modes 1, 2 and 0. It judges each output cycle against the result that sample's own mode requires. Clamping and conversion also coincide: inputs whose exact result lies outside 0..1023 are checked for the clamped code in the same output cycle as the unclamped neighbours.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int DATA_W = 10;
    localparam int CALC_W = DATA_W + 3;

    typedef enum logic [1:0] {
        CSC_PASS     = 2'd0,
        CSC_TO_YCC   = 2'd1,
        CSC_TO_RGB   = 2'd2,
        CSC_PASS_ALT = 2'd3
    } csc_mode_e;

    typedef struct packed {
        logic                     valid;
        csc_mode_e                mode;
        logic signed [CALC_W-1:0] c0;
        logic signed [CALC_W-1:0] c1;
        logic signed [CALC_W-1:0] c2;
    } csc_beat_t;

    typedef struct packed {
        logic                     valid;
        logic signed [CALC_W-1:0] c0;
        logic signed [CALC_W-1:0] c1;
        logic signed [CALC_W-1:0] c2;
    } csc_res_t;

    localparam real CSC_KR     = 0.2126;
    localparam real CSC_KB     = 0.0722;
    localparam real CSC_KG     = 1.0 - CSC_KR - CSC_KB;
    localparam real CSC_NARROW = 224.0 / 219.0;

    // positive real coefficient to fixed point with frac fractional bits
    function automatic int csc_fx(real v, int frac);
        return $rtoi(v * $itor(1 << frac) + 0.5);
    endfunction

    // add half an LSB, then drop the fraction
    function automatic logic signed [CALC_W-1:0] csc_round(longint acc, int frac);
        longint t;
        t = (acc + (longint'(1) <<< (frac - 1))) >>> frac;
        return t[CALC_W-1:0];
    endfunction

    function automatic logic signed [CALC_W-1:0] csc_widen(logic [DATA_W-1:0] v);
        return signed'({{(CALC_W-DATA_W){1'b0}}, v});
    endfunction

endpackage

// File: rtl/csc_stage_matrix.sv
module csc_stage_matrix
    import csc_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_mode,
    input  logic [DATA_W-1:0] in_c0,
    input  logic [DATA_W-1:0] in_c1,
    input  logic [DATA_W-1:0] in_c2,
    output csc_beat_t         beat_o
);

    localparam longint K_YR   = longint'(csc_fx(CSC_KR, FRAC_W));
    localparam longint K_YG   = longint'(csc_fx(CSC_KG, FRAC_W));
    localparam longint K_YB   = longint'(csc_fx(CSC_KB, FRAC_W));
    localparam real    INV_R  = 2.0 * (1.0 - CSC_KR) / CSC_NARROW;
    localparam real    INV_B  = 2.0 * (1.0 - CSC_KB) / CSC_NARROW;
    localparam longint K_RCR  = longint'(csc_fx(INV_R, FRAC_W));
    localparam longint K_BCB  = longint'(csc_fx(INV_B, FRAC_W));
    localparam longint K_GCB  = longint'(csc_fx(INV_B * CSC_KB / CSC_KG, FRAC_W));
    localparam longint K_GCR  = longint'(csc_fx(INV_R * CSC_KR / CSC_KG, FRAC_W));
    localparam longint MID    = longint'(1) <<< (DATA_W - 1);

    csc_beat_t beat_d, beat_q;

    always_comb begin
        longint y_fx;
        longint b_off;
        longint r_off;
        y_fx         = longint'(in_c0) <<< FRAC_W;
        b_off        = longint'(in_c1) - MID;
        r_off        = longint'(in_c2) - MID;
        beat_d.valid = in_valid;
        beat_d.mode  = csc_mode_e'(in_mode);
        beat_d.c0    = csc_widen(in_c0);
        beat_d.c1    = csc_widen(in_c1);
        beat_d.c2    = csc_widen(in_c2);
        case (beat_d.mode)
            CSC_TO_YCC: begin
                beat_d.c0 = csc_round(K_YR * longint'(in_c0) + K_YG * longint'(in_c1)
                                      + K_YB * longint'(in_c2), FRAC_W);
                beat_d.c1 = csc_widen(in_c2);
                beat_d.c2 = csc_widen(in_c0);
            end
            CSC_TO_RGB: begin
                beat_d.c0 = csc_round(y_fx + K_RCR * r_off, FRAC_W);
                beat_d.c1 = csc_round(y_fx - K_GCB * b_off - K_GCR * r_off, FRAC_W);
                beat_d.c2 = csc_round(y_fx + K_BCB * b_off, FRAC_W);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= beat_d;
    end

    assign beat_o = beat_q;

endmodule

// File: rtl/csc_stage_chroma.sv
module csc_stage_chroma
    import csc_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  csc_beat_t beat_i,
    output csc_res_t  res_o
);

    localparam longint K_CB  = longint'(csc_fx(CSC_NARROW / (2.0 * (1.0 - CSC_KB)), FRAC_W));
    localparam longint K_CR  = longint'(csc_fx(CSC_NARROW / (2.0 * (1.0 - CSC_KR)), FRAC_W));
    localparam longint MID_F = (longint'(1) <<< (DATA_W - 1)) <<< FRAC_W;

    csc_res_t res_d, res_q;

    always_comb begin
        longint luma;
        luma        = longint'(beat_i.c0);
        res_d.valid = beat_i.valid;
        res_d.c0    = beat_i.c0;
        res_d.c1    = beat_i.c1;
        res_d.c2    = beat_i.c2;
        if (beat_i.mode == CSC_TO_YCC) begin
            // c1 carries blue, c2 carries red, c0 the already rounded luma
            res_d.c1 = csc_round(K_CB * (longint'(beat_i.c1) - luma) + MID_F, FRAC_W);
            res_d.c2 = csc_round(K_CR * (longint'(beat_i.c2) - luma) + MID_F, FRAC_W);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_o = res_q;

endmodule

// File: rtl/csc_stage_clip.sv
module csc_stage_clip
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  csc_res_t          res_i,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_c0,
    output logic [DATA_W-1:0] out_c1,
    output logic [DATA_W-1:0] out_c2
);

    localparam logic signed [CALC_W-1:0] TOP_CODE = CALC_W'((1 << DATA_W) - 1);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] c0;
        logic [DATA_W-1:0] c1;
        logic [DATA_W-1:0] c2;
    } clip_t;

    function automatic logic [DATA_W-1:0] clamp(logic signed [CALC_W-1:0] v);
        logic signed [CALC_W-1:0] t;
        if (v < 0)             t = '0;
        else if (v > TOP_CODE) t = TOP_CODE;
        else                   t = v;
        return t[DATA_W-1:0];
    endfunction

    clip_t clip_d, clip_q;

    always_comb begin
        clip_d.valid = res_i.valid;
        clip_d.c0    = clamp(res_i.c0);
        clip_d.c1    = clamp(res_i.c1);
        clip_d.c2    = clamp(res_i.c2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) clip_q <= '0;
        else        clip_q <= clip_d;
    end

    assign out_valid = clip_q.valid;
    assign out_c0    = clip_q.c0;
    assign out_c1    = clip_q.c1;
    assign out_c2    = clip_q.c2;

endmodule

// File: rtl/csc_bt709.sv
module csc_bt709
    import csc_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_mode,
    input  logic [DATA_W-1:0] in_c0,
    input  logic [DATA_W-1:0] in_c1,
    input  logic [DATA_W-1:0] in_c2,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_c0,
    output logic [DATA_W-1:0] out_c1,
    output logic [DATA_W-1:0] out_c2
);

    csc_beat_t s1_beat;
    csc_res_t  s2_res;

    csc_stage_matrix #(.FRAC_W(FRAC_W)) u_matrix (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_mode  (in_mode),
        .in_c0    (in_c0),
        .in_c1    (in_c1),
        .in_c2    (in_c2),
        .beat_o   (s1_beat)
    );

    csc_stage_chroma #(.FRAC_W(FRAC_W)) u_chroma (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_i (s1_beat),
        .res_o  (s2_res)
    );

    csc_stage_clip u_clip (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_i     (s2_res),
        .out_valid (out_valid),
        .out_c0    (out_c0),
        .out_c1    (out_c1),
        .out_c2    (out_c2)
    );

endmodule

// File: rtl/csc_bt709_chk.sv
module csc_bt709_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] in_mode,
    input logic [9:0] in_c0,
    input logic [9:0] in_c1,
    input logic [9:0] in_c2,
    input logic       out_valid,
    input logic [9:0] out_c0,
    input logic [9:0] out_c1,
    input logic [9:0] out_c2
);

    logic [1:0] warm_q;
    logic       warm;

    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    assign warm = (warm_q == 2'd3);

    // R7: strobe delayed by exactly three edges
    a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 3)));

    // R1: pass modes leave data untouched
    a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 3) && ($past(in_mode, 3) == 2'd0 || $past(in_mode, 3) == 2'd3))
        |-> (out_c0 == $past(in_c0, 3) && out_c1 == $past(in_c1, 3) && out_c2 == $past(in_c2, 3)));

    // R10: grey R'G'B' gives zero colour difference
    a_r10_grey_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 3) && $past(in_mode, 3) == 2'd1
         && $past(in_c0, 3) == $past(in_c1, 3) && $past(in_c1, 3) == $past(in_c2, 3))
        |-> (out_c0 == $past(in_c0, 3) && out_c1 == 10'd512 && out_c2 == 10'd512));

    // R10: neutral chroma gives equal R'G'B'
    a_r10_neutral_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 3) && $past(in_mode, 3) == 2'd2
         && $past(in_c1, 3) == 10'd512 && $past(in_c2, 3) == 10'd512)
        |-> (out_c0 == $past(in_c0, 3) && out_c1 == $past(in_c0, 3) && out_c2 == $past(in_c0, 3)));

endmodule

bind csc_bt709 csc_bt709_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_c0     (in_c0),
    .in_c1     (in_c1),
    .in_c2     (in_c2),
    .out_valid (out_valid),
    .out_c0    (out_c0),
    .out_c1    (out_c1),
    .out_c2    (out_c2)
);

// File: tb/sim_csc_bt709.sv
`timescale 1ns/1ps
module sim_csc_bt709;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_mode = 2'd0;
    logic [9:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic       out_valid;
    logic [9:0] out_c0, out_c1, out_c2;

    int checks = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    csc_bt709 u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
    );

    // {req, mode, in0, in1, in2, exp0, exp1, exp2}
    localparam int NV = 12;
    localparam logic [65:0] VEC [NV] = '{
        {4'd2,  2'd1, 10'd255, 10'd0,   10'd0,    10'd54,  10'd482,  10'd643},  // R2 R3
        {4'd3,  2'd1, 10'd940, 10'd64,  10'd64,   10'd250, 10'd409,  10'd960},  // R3
        {4'd3,  2'd1, 10'd0,   10'd255, 10'd0,    10'd182, 10'd412,  10'd394},  // R3
        {4'd10, 2'd1, 10'd64,  10'd64,  10'd64,   10'd64,  10'd512,  10'd512},  // R10
        {4'd4,  2'd2, 10'd54,  10'd482, 10'd643,  10'd256, 10'd0,    10'd0},    // R4
        {4'd4,  2'd2, 10'd250, 10'd409, 10'd960,  10'd940, 10'd64,   10'd63},   // R4
        {4'd4,  2'd2, 10'd182, 10'd412, 10'd394,  10'd0,   10'd254,  10'd1},    // R4
        {4'd6,  2'd1, 10'd0,   10'd0,   10'd1023, 10'd74,  10'd1023, 10'd464},  // R6
        {4'd6,  2'd2, 10'd0,   10'd512, 10'd1023, 10'd787, 10'd0,    10'd0},    // R6
        {4'd6,  2'd2, 10'd0,   10'd0,   10'd0,    10'd0,   10'd328,  10'd0},    // R6
        {4'd1,  2'd0, 10'd1,   10'd2,   10'd1023, 10'd1,   10'd2,    10'd1023}, // R1
        {4'd1,  2'd3, 10'd700, 10'd3,   10'd9,    10'd700, 10'd3,    10'd9}     // R1
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input string what, input int act, input int exp);
        checks++;
        if (act > exp + 2 || act < exp - 2) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d+-2", req, what, act, exp);
        end
    endtask

    // drive one sample, wait until its result is on the outputs
    task automatic apply(input logic [1:0] m, input int a, input int b, input int c,
                         output int o0, output int o1, output int o2, output int ov);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m;
        in_c0 = 10'(a); in_c1 = 10'(b); in_c2 = 10'(c);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        o0 = int'(out_c0); o1 = int'(out_c1); o2 = int'(out_c2); ov = int'(out_valid);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin : main
        int o0, o1, o2, ov;
        // R9: reset state
        repeat (4) @(negedge clk);
        chk("R9", "valid in reset", int'(out_valid), 0);
        chk("R9", "c0 in reset", int'(out_c0), 0);
        chk("R9", "c2 in reset", int'(out_c2), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: strobe timing, one sample
        in_valid = 1'b1; in_mode = 2'd1; in_c0 = 10'd255; in_c1 = 10'd0; in_c2 = 10'd0;
        @(negedge clk); in_valid = 1'b0;
        chk("R7", "valid after 1 edge", int'(out_valid), 0);
        @(negedge clk);
        chk("R7", "valid after 2 edges", int'(out_valid), 0);
        @(negedge clk);
        chk("R7", "valid after 3 edges", int'(out_valid), 1);
        chk("R7", "data after 3 edges", int'(out_c2), 643);
        @(negedge clk);
        chk("R7", "valid after 4 edges", int'(out_valid), 0);

        // table of directed vectors (R1 R2 R3 R4 R6 R10)
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", int'(VEC[i][65:62]));
            apply(VEC[i][61:60], int'(VEC[i][59:50]), int'(VEC[i][49:40]), int'(VEC[i][39:30]),
                  o0, o1, o2, ov);
            chk(rq, $sformatf("vec%0d valid", i), ov, 1);
            chk(rq, $sformatf("vec%0d c0", i), o0, int'(VEC[i][29:20]));
            chk(rq, $sformatf("vec%0d c1", i), o1, int'(VEC[i][19:10]));
            chk(rq, $sformatf("vec%0d c2", i), o2, int'(VEC[i][9:0]));
        end

        // R8: back-to-back samples in three different modes
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'd1; in_c0 = 10'd255; in_c1 = 10'd0;   in_c2 = 10'd0;
        @(negedge clk);
        in_mode = 2'd2; in_c0 = 10'd54; in_c1 = 10'd482; in_c2 = 10'd643;
        @(negedge clk);
        in_mode = 2'd0; in_c0 = 10'd5;  in_c1 = 10'd6;   in_c2 = 10'd7;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", "beat A c0", int'(out_c0), 54);
        chk("R8", "beat A c1", int'(out_c1), 482);
        chk("R8", "beat A c2", int'(out_c2), 643);
        @(negedge clk);
        chk("R8", "beat B c0", int'(out_c0), 256);
        chk("R8", "beat B c1", int'(out_c1), 0);
        chk("R8", "beat B valid", int'(out_valid), 1);
        @(negedge clk);
        chk("R8", "beat C c0", int'(out_c0), 5);
        chk("R8", "beat C c2", int'(out_c2), 7);
        @(negedge clk);
        chk("R7", "valid drops after burst", int'(out_valid), 0);

        // R5: round trip within two codes
        for (int k = 0; k < 3; k++) begin
            int r, g, b, y, cb, cr;
            r = (k == 0) ? 300 : (k == 1) ? 940 : 100;
            g = (k == 0) ? 700 : (k == 1) ? 940 : 500;
            b = (k == 0) ? 120 : (k == 1) ? 64  : 900;
            apply(2'd1, r, g, b, y, cb, cr, ov);
            apply(2'd2, y, cb, cr, o0, o1, o2, ov);
            chk_near("R5", $sformatf("trip%0d R", k), o0, r);
            chk_near("R5", $sformatf("trip%0d G", k), o1, g);
            chk_near("R5", $sformatf("trip%0d B", k), o2, b);
        end

        // R9: reset in mid-flight clears the outputs
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'd0; in_c0 = 10'd33;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R9", "valid after mid reset", int'(out_valid), 0);
        chk("R9", "c0 after mid reset", int'(out_c0), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9", "no stale sample", int'(out_valid), 0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule